// File: doc/BRIEF.md
# Display Controller Host Register Port

This block is the host-facing register access unit of a display controller. A host on a 16-bit parallel bus drives a select line beside each bus cycle: with select low a write loads an 8-bit register index, and with select high each access reads or writes the register that the index points at. After the access the index moves on by itself, so the host can walk through neighbouring registers without sending a new index for each one.

The unit holds a few directly mapped control registers with write masks. It also holds four 10-bit window coordinates, each split over a low and a high register. Two tables are reached indirectly through a pointer and a data port that steps the pointer forward: a 256-entry tone-curve table that wraps, and a 32-entry filter-coefficient table that stops at its end. A sticky interrupt status register collects event bits and is cleared by writing zeros. A skip counter can be loaded so that the next few bus accesses are dropped. Any data access to an index with no register behind it raises a one-cycle error pulse.

Top module: `disp_reg_access`

## Requirements
- R1: A write with `sel` low (a command cycle) loads the register index from `wdata[7:0]`; the index is 0 after reset.
- R2: A write with `sel` high stores data into the register at the index and then adds 2 to the index, except at the stream ports 0x90, 0x5A and 0xB8, where the index stays put.
- R3: A read with `sel` high presents the register at the index on `rdata[7:0]` (upper byte zero) one cycle later with `rd_vld` high, and then adds 1 to the index at every index. A read with `sel` low returns 0 and changes nothing.
- R4: `skip_load` loads the skip counter from `skip_val`. While the counter is nonzero, each access of either kind and either select level decrements it and is dropped: writes change nothing and reads return 0 with `rd_vld` high.
- R5: Four 10-bit window fields sit at 0x6C+4k (bits 7:0, written from `wdata[7:0]`) and 0x6E+4k (bits 9:8, written from `wdata[1:0]`), k = 0..3. A write to one half leaves the other half unchanged. The high register reads back bits 9:8 in `rdata[1:0]`.
- R6: Writing 0xB6 sets the tone-table pointer to `wdata[7:0]`, and reading 0xB6 returns it. Each data read or write at 0xB8 accesses the entry at the pointer and then adds 1 to the pointer modulo 256.
- R7: Writing 0x58 sets the filter pointer to `wdata[4:0]`, and reading 0x58 returns the pointer (0..32). Each access at 0x5A uses the entry at the pointer and then adds 1 to the pointer. Once the pointer reaches 32, writes are ignored, reads return 0 and the pointer stays at 32.
- R8: Interrupt status at 0xF6 gathers `irq_evt` bits each cycle. A data write there ANDs the stored status with `wdata[7:0]`, and an event bit arriving in the same cycle is still set.
- R9: Index 0x00 reads 0x00A5 and index 0x02 reads 0x0083. Writes to either change nothing and count as unmapped.
- R10: A write to 0x04 stores (`wdata[5:0]` + 1). A read returns 0x80 OR (stored − 1). The reset value stored is 9, so the register reads 0x88 after reset.
- R11: 0x06 keeps `wdata[1:0]` (reset 1). 0x1C keeps `wdata[6:0]` (reset 0x3F).
- R12: Mapped indices are 0x00, 0x02, 0x04, 0x06, 0x1C, 0x58, 0x5A, 0x6C–0x7A (even), 0xB6, 0xB8 and 0xF6, where 0x00 and 0x02 are mapped for reads only. Any other data access reads 0, writes nothing, still moves the index, and drives `bad_idx` high for one cycle, in the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Low: command cycle; high: data cycle |
| wr_en | input | 1 | Write strobe (wins over `rd_en`) |
| rd_en | input | 1 | Read strobe |
| wdata | input | 16 | Write data / index value |
| skip_load | input | 1 | Load the skip counter |
| skip_val | input | 4 | Number of accesses to drop |
| irq_evt | input | 8 | Interrupt event bits to latch |
| rdata | output | 16 | Read data, valid with `rd_vld` |
| rd_vld | output | 1 | Read completed in the previous cycle |
| bad_idx | output | 1 | Previous data access hit an unmapped index |

## Verification
The bench targets the places where the index and the table pointers move differently. It checks that writes step by two and reads by one, so a design that used one step size for both would land on the wrong register on the next read. It repeats writes at 0xB8 and 0x5A to show that the stream ports hold the index, and runs the tone table across its 255→0 wrap and the filter table into its stop at 32. A design that wrapped the filter pointer, or let it advance past 32, would return stale coefficients instead of 0. It also rewrites one half of a split field and reads back the other half, drops accesses under a loaded skip count, and writes to the read-only constants. A design that lost a half on a write, leaked a dropped access, or failed to flag a read-only write would show a wrong readback or a missing error pulse.

// File: rtl/disp_reg_pkg.sv
package disp_reg_pkg;
  localparam int IDX_W = 8;

  localparam logic [IDX_W-1:0] A_REV   = 8'h00;
  localparam logic [IDX_W-1:0] A_CFG   = 8'h02;
  localparam logic [IDX_W-1:0] A_DIV   = 8'h04;
  localparam logic [IDX_W-1:0] A_LOCK  = 8'h06;
  localparam logic [IDX_W-1:0] A_PWR   = 8'h1C;
  localparam logic [IDX_W-1:0] A_FIDX  = 8'h58;
  localparam logic [IDX_W-1:0] A_FDAT  = 8'h5A;
  localparam logic [IDX_W-1:0] A_WIN   = 8'h6C;
  localparam logic [IDX_W-1:0] A_PIX   = 8'h90;
  localparam logic [IDX_W-1:0] A_GIDX  = 8'hB6;
  localparam logic [IDX_W-1:0] A_GDAT  = 8'hB8;
  localparam logic [IDX_W-1:0] A_IRQ   = 8'hF6;

  localparam logic [7:0] REV_CODE = 8'hA5;
  localparam logic [7:0] CFG_CODE = 8'h83;

  // Data ports that keep the index still on writes.
  function automatic logic is_stream(input logic [IDX_W-1:0] a);
    return (a == A_PIX) || (a == A_FDAT) || (a == A_GDAT);
  endfunction

  function automatic logic [9:0] merge_lo(input logic [9:0] cur, input logic [7:0] v);
    return {cur[9:8], v};
  endfunction

  function automatic logic [9:0] merge_hi(input logic [9:0] cur, input logic [1:0] v);
    return {v, cur[7:0]};
  endfunction

  function automatic logic [6:0] div_store(input logic [5:0] v);
    return 7'(v) + 7'd1;
  endfunction

  function automatic logic [7:0] div_view(input logic [6:0] s);
    logic [6:0] t;
    t = s - 7'd1;
    return {1'b1, t};
  endfunction
endpackage

// File: rtl/disp_idx_ctrl.sv
module disp_idx_ctrl
  import disp_reg_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             skip_load,
  input  logic [CW-1:0]    skip_val,
  input  logic             access,
  input  logic             cmd_wr,
  input  logic             dat_wr,
  input  logic             dat_rd,
  input  logic [IDX_W-1:0] cmd_val,
  output logic [IDX_W-1:0] idx,
  output logic             swallow
);
  localparam logic [IDX_W-1:0] WR_STEP = IDX_W'(2);
  localparam logic [IDX_W-1:0] RD_STEP = IDX_W'(1);

  logic [CW-1:0] cnt_q;

  assign swallow = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (skip_load)         cnt_q <= skip_val;
    else if (access && swallow) cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        idx <= '0;
    else if (cmd_wr)                   idx <= cmd_val;
    else if (dat_wr && !is_stream(idx)) idx <= idx + WR_STEP;
    else if (dat_rd)                   idx <= idx + RD_STEP;
  end
endmodule

// File: rtl/disp_ind_table.sv
module disp_ind_table #(
  parameter int  DEPTH = 256,
  parameter bit  WRAP  = 1'b1,
  parameter int  DW    = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = WRAP ? AW : AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_ptr,
  input  logic [DW-1:0] set_val,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [PW-1:0] ptr
);
  logic [DW-1:0] mem [DEPTH];
  logic          in_range;
  logic          unused_set;

  assign unused_set = ^set_val;

  generate
    if (WRAP) begin : g_wrap
      assign in_range = 1'b1;
    end else begin : g_stop
      assign in_range = (ptr < PW'(DEPTH));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr && in_range) mem[ptr[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       ptr <= '0;
    else if (set_ptr)                 ptr <= PW'(set_val[AW-1:0]);
    else if ((wr || rd) && in_range)  ptr <= ptr + 1'b1;
  end

  assign rdata = in_range ? mem[ptr[AW-1:0]] : '0;
endmodule

// File: rtl/disp_reg_file.sv
module disp_reg_file
  import disp_reg_pkg::*;
#(
  parameter int NWIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wdata,
  input  logic [7:0]       irq_evt,
  output logic [7:0]       rval,
  output logic             rhit,
  output logic             whit
);
  logic [6:0]      div_q;
  logic [1:0]      lock_q;
  logic [6:0]      pwr_q;
  logic [7:0]      irq_q;
  logic [9:0]      win [NWIN];
  logic [NWIN-1:0] lo_sel, hi_sel;

  genvar k;
  generate
    for (k = 0; k < NWIN; k++) begin : g_win
      logic [9:0] fld_q;
      assign lo_sel[k] = (idx == A_WIN + IDX_W'(4 * k));
      assign hi_sel[k] = (idx == A_WIN + IDX_W'(4 * k + 2));
      always_ff @(posedge clk) begin
        if (!rst_n)                fld_q <= '0;
        else if (we && lo_sel[k])  fld_q <= merge_lo(fld_q, wdata);
        else if (we && hi_sel[k])  fld_q <= merge_hi(fld_q, wdata[1:0]);
      end
      assign win[k] = fld_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= 7'd9;
      lock_q <= 2'd1;
      pwr_q  <= 7'h3F;
      irq_q  <= '0;
    end else begin
      if (we && idx == A_DIV)  div_q  <= div_store(wdata[5:0]);
      if (we && idx == A_LOCK) lock_q <= wdata[1:0];
      if (we && idx == A_PWR)  pwr_q  <= wdata[6:0];
      irq_q <= ((we && idx == A_IRQ) ? (irq_q & wdata) : irq_q) | irq_evt;
    end
  end

  always_comb begin
    rval = '0;
    rhit = 1'b1;
    unique case (idx)
      A_REV:  rval = REV_CODE;
      A_CFG:  rval = CFG_CODE;
      A_DIV:  rval = div_view(div_q);
      A_LOCK: rval = {6'b0, lock_q};
      A_PWR:  rval = {1'b0, pwr_q};
      A_IRQ:  rval = irq_q;
      default: begin
        rhit = 1'b0;
        for (int i = 0; i < NWIN; i++) begin
          if (lo_sel[i]) begin rval = win[i][7:0];         rhit = 1'b1; end
          if (hi_sel[i]) begin rval = {6'b0, win[i][9:8]}; rhit = 1'b1; end
        end
      end
    endcase
  end

  assign whit = (|lo_sel) || (|hi_sel) ||
                (idx == A_DIV) || (idx == A_LOCK) || (idx == A_PWR) || (idx == A_IRQ);
endmodule

// File: rtl/disp_reg_access.sv
module disp_reg_access
  import disp_reg_pkg::*;
#(
  parameter int SKIP_W  = 4,
  parameter int NWIN    = 4,
  parameter int GAMMA_N = 256,
  parameter int FILT_N  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [15:0]       wdata,
  input  logic              skip_load,
  input  logic [SKIP_W-1:0] skip_val,
  input  logic [7:0]        irq_evt,
  output logic [15:0]       rdata,
  output logic              rd_vld,
  output logic              bad_idx
);
  localparam int G_PW = $clog2(GAMMA_N);
  localparam int F_PW = $clog2(FILT_N) + 1;

  logic             rd_go, access, swallow;
  logic             cmd_wr, dat_wr, dat_rd;
  logic [IDX_W-1:0] idx;
  logic [7:0]       rf_rval, rd_mux;
  logic             rf_rhit, rf_whit, rd_hit, wr_hit;
  logic [7:0]       g_rdata, f_rdata;
  logic [G_PW-1:0]  g_ptr;
  logic [F_PW-1:0]  f_ptr;
  logic             unused_hi;

  assign unused_hi = ^wdata[15:8];

  assign rd_go  = rd_en & ~wr_en;
  assign access = wr_en | rd_go;
  assign cmd_wr = wr_en & ~sel & ~swallow;
  assign dat_wr = wr_en &  sel & ~swallow;
  assign dat_rd = rd_go &  sel & ~swallow;

  disp_idx_ctrl #(.CW(SKIP_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .skip_load(skip_load), .skip_val(skip_val),
    .access(access), .cmd_wr(cmd_wr), .dat_wr(dat_wr), .dat_rd(dat_rd),
    .cmd_val(wdata[7:0]), .idx(idx), .swallow(swallow)
  );

  disp_reg_file #(.NWIN(NWIN)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(dat_wr), .idx(idx), .wdata(wdata[7:0]),
    .irq_evt(irq_evt), .rval(rf_rval), .rhit(rf_rhit), .whit(rf_whit)
  );

  disp_ind_table #(.DEPTH(GAMMA_N), .WRAP(1'b1), .DW(8)) u_gamma (
    .clk(clk), .rst_n(rst_n),
    .set_ptr(dat_wr && idx == A_GIDX), .set_val(wdata[7:0]),
    .wr(dat_wr && idx == A_GDAT), .rd(dat_rd && idx == A_GDAT),
    .wdata(wdata[7:0]), .rdata(g_rdata), .ptr(g_ptr)
  );

  disp_ind_table #(.DEPTH(FILT_N), .WRAP(1'b0), .DW(8)) u_filt (
    .clk(clk), .rst_n(rst_n),
    .set_ptr(dat_wr && idx == A_FIDX), .set_val(wdata[7:0]),
    .wr(dat_wr && idx == A_FDAT), .rd(dat_rd && idx == A_FDAT),
    .wdata(wdata[7:0]), .rdata(f_rdata), .ptr(f_ptr)
  );

  always_comb begin
    rd_mux = rf_rval;
    rd_hit = rf_rhit;
    wr_hit = rf_whit;
    unique case (idx)
      A_GIDX: begin rd_mux = 8'(g_ptr); rd_hit = 1'b1; wr_hit = 1'b1; end
      A_GDAT: begin rd_mux = g_rdata;   rd_hit = 1'b1; wr_hit = 1'b1; end
      A_FIDX: begin rd_mux = 8'(f_ptr); rd_hit = 1'b1; wr_hit = 1'b1; end
      A_FDAT: begin rd_mux = f_rdata;   rd_hit = 1'b1; wr_hit = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata   <= '0;
      rd_vld  <= 1'b0;
      bad_idx <= 1'b0;
    end else begin
      rd_vld  <= rd_go;
      if (rd_go) rdata <= dat_rd ? {8'h00, rd_mux} : 16'h0000;
      bad_idx <= (dat_wr & ~wr_hit) | (dat_rd & ~rd_hit);
    end
  end
endmodule

// File: rtl/disp_reg_access_chk.sv
module disp_reg_access_chk #(
  parameter int FPW    = 6,
  parameter int FDEPTH = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic           rd_en,
  input logic [7:0]     cmd_val,
  input logic [15:0]    rdata,
  input logic           rd_vld,
  input logic           bad_idx,
  input logic [7:0]     idx,
  input logic           swallow,
  input logic           cmd_wr,
  input logic           dat_wr,
  input logic           dat_rd,
  input logic [FPW-1:0] filt_ptr
);
  logic rd_go, stream_at;
  assign rd_go     = rd_en & ~wr_en;
  assign stream_at = (idx == 8'h90) || (idx == 8'h5A) || (idx == 8'hB8);

  p_cmd_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> idx == $past(cmd_val));

  p_wr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !stream_at) |=> idx == $past(idx) + 8'd2);

  p_stream_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && stream_at) |=> $stable(idx));

  p_rd_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dat_rd |=> (idx == $past(idx) + 8'd1) && rd_vld);

  p_vld_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> $past(rd_go));

  p_drop_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    swallow |=> $stable(idx));

  p_drop_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (swallow && rd_go) |=> rdata == 16'h0000);

  p_filt_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    filt_ptr <= FPW'(FDEPTH));

  p_bad_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bad_idx |-> $past(dat_wr || dat_rd));
endmodule

bind disp_reg_access disp_reg_access_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .cmd_val(wdata[7:0]),
  .rdata(rdata), .rd_vld(rd_vld), .bad_idx(bad_idx), .idx(idx), .swallow(swallow),
  .cmd_wr(cmd_wr), .dat_wr(dat_wr), .dat_rd(dat_rd), .filt_ptr(f_ptr)
);

// File: tb/disp_reg_access_bench.sv
`timescale 1ns/1ps
module disp_reg_access_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wdata = '0;
  logic        skip_load = 1'b0;
  logic [3:0]  skip_val = '0;
  logic [7:0]  irq_evt = '0;
  logic [15:0] rdata;
  logic        rd_vld, bad_idx;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  disp_reg_access u_disp_reg_access (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .skip_load(skip_load), .skip_val(skip_val), .irq_evt(irq_evt),
    .rdata(rdata), .rd_vld(rd_vld), .bad_idx(bad_idx)
  );

  // {req id, op (0 index, 1 write, 2 read+check), value, expected}
  localparam int NV = 37;
  localparam logic [37:0] VEC [NV] = '{
    {4'd1,  2'd0, 16'h0000, 16'h0000}, {4'd9,  2'd2, 16'h0000, 16'h00A5},
    {4'd1,  2'd0, 16'h0002, 16'h0000}, {4'd1,  2'd2, 16'h0000, 16'h0083},
    {4'd10, 2'd0, 16'h0004, 16'h0000}, {4'd10, 2'd2, 16'h0000, 16'h0088},
    {4'd10, 2'd0, 16'h0004, 16'h0000}, {4'd10, 2'd1, 16'h00FF, 16'h0000},
    {4'd11, 2'd1, 16'h0002, 16'h0000},  // lands on 0x06 after a +2 step
    {4'd10, 2'd0, 16'h0004, 16'h0000}, {4'd10, 2'd2, 16'h0000, 16'h00BF},
    {4'd12, 2'd2, 16'h0000, 16'h0000},  // 0x05 unmapped
    {4'd2,  2'd2, 16'h0000, 16'h0002},  // 0x06 holds masked value
    {4'd11, 2'd0, 16'h001C, 16'h0000}, {4'd11, 2'd2, 16'h0000, 16'h003F},
    {4'd11, 2'd0, 16'h001C, 16'h0000}, {4'd11, 2'd1, 16'hFFFF, 16'h0000},
    {4'd11, 2'd0, 16'h001C, 16'h0000}, {4'd11, 2'd2, 16'h0000, 16'h007F},
    {4'd5,  2'd0, 16'h006C, 16'h0000}, {4'd5,  2'd1, 16'h01AB, 16'h0000},
    {4'd5,  2'd1, 16'h0007, 16'h0000}, {4'd5,  2'd1, 16'h0055, 16'h0000},
    {4'd5,  2'd0, 16'h006C, 16'h0000}, {4'd5,  2'd2, 16'h0000, 16'h00AB},
    {4'd12, 2'd2, 16'h0000, 16'h0000},  // 0x6D unmapped
    {4'd5,  2'd2, 16'h0000, 16'h0003},
    {4'd5,  2'd0, 16'h006C, 16'h0000}, {4'd5,  2'd1, 16'h0012, 16'h0000},
    {4'd5,  2'd0, 16'h006E, 16'h0000}, {4'd5,  2'd2, 16'h0000, 16'h0003},
    {4'd5,  2'd0, 16'h006C, 16'h0000}, {4'd5,  2'd2, 16'h0000, 16'h0012},
    {4'd5,  2'd0, 16'h0070, 16'h0000}, {4'd5,  2'd2, 16'h0000, 16'h0055},
    {4'd3,  2'd0, 16'h0000, 16'h0000}, {4'd3,  2'd2, 16'h0000, 16'h00A5}
  };

  function automatic string req_name(input logic [3:0] id);
    case (id)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11"; 4'd12: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic s, input logic [15:0] v);
    @(negedge clk); sel = s; wdata = v; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic s, output logic [15:0] d, output logic v, output logic b);
    @(negedge clk); sel = s; rd_en = 1'b1;
    @(negedge clk); d = rdata; v = rd_vld; b = bad_idx; rd_en = 1'b0;
  endtask

  task automatic load_skip(input logic [3:0] n);
    @(negedge clk); skip_val = n; skip_load = 1'b1;
    @(negedge clk); skip_load = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] exp);
    logic [15:0] d; logic v, b;
    bus_rd(1'b1, d, v, b);
    check(tag, d, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d; logic v, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    check("R13 rd_vld", {15'b0, rd_vld}, 16'h0000);
    check("R13 bad_idx", {15'b0, bad_idx}, 16'h0000);
    check("R13 rdata", rdata, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][33:32])
        2'd0: bus_wr(1'b0, VEC[i][31:16]);
        2'd1: bus_wr(1'b1, VEC[i][31:16]);
        default: rd_chk(req_name(VEC[i][37:34]), VEC[i][15:0]);
      endcase
    end

    // R3 valid strobe and select-low read
    bus_wr(1'b0, 16'h0000);
    bus_rd(1'b0, d, v, b);
    check("R3 sel-low read data", d, 16'h0000);
    check("R3 rd_vld", {15'b0, v}, 16'h0001);
    rd_chk("R3 index unchanged by sel-low read", 16'h00A5);

    // R9 / R12 write to read-only constant is flagged and ignored
    bus_wr(1'b0, 16'h0000);
    bus_wr(1'b1, 16'h1234);
    check("R9 write to constant flagged", {15'b0, bad_idx}, 16'h0001);
    bus_wr(1'b0, 16'h0000);
    bus_rd(1'b1, d, v, b);
    check("R9 constant kept", d, 16'h00A5);
    check("R12 no flag on mapped read", {15'b0, b}, 16'h0000);
    bus_wr(1'b0, 16'h0008);
    bus_wr(1'b1, 16'h0001);
    check("R12 unmapped write flagged", {15'b0, bad_idx}, 16'h0001);

    // R6 tone table with wrap; stream port holds index (R2)
    bus_wr(1'b0, 16'h00B6);
    bus_wr(1'b1, 16'h00FE);
    bus_wr(1'b1, 16'h0011);
    bus_wr(1'b1, 16'h0022);
    bus_wr(1'b1, 16'h0033);
    bus_wr(1'b0, 16'h00B6);
    rd_chk("R6 pointer wrapped", 16'h0001);
    bus_wr(1'b0, 16'h00B6);
    bus_wr(1'b1, 16'h00FE);
    rd_chk("R2 stream index held at 0xB8", 16'h0011);
    bus_wr(1'b0, 16'h00B8);
    rd_chk("R6 entry 0xFF", 16'h0022);
    bus_wr(1'b0, 16'h00B8);
    rd_chk("R6 entry 0x00 after wrap", 16'h0033);

    // R7 filter table stops at 32
    bus_wr(1'b0, 16'h0058);
    bus_wr(1'b1, 16'h001E);
    bus_wr(1'b1, 16'h00A1);
    bus_wr(1'b1, 16'h00A2);
    bus_wr(1'b1, 16'h00A3);
    bus_wr(1'b0, 16'h0058);
    rd_chk("R7 pointer stops at 32", 16'h0020);
    bus_wr(1'b0, 16'h0058);
    bus_wr(1'b1, 16'h003E);
    bus_wr(1'b0, 16'h005A);
    rd_chk("R7 masked pointer entry 30", 16'h00A1);
    bus_wr(1'b0, 16'h005A);
    rd_chk("R7 entry 31", 16'h00A2);
    bus_wr(1'b0, 16'h005A);
    rd_chk("R7 read past end", 16'h0000);
    bus_wr(1'b0, 16'h0058);
    rd_chk("R7 pointer still 32", 16'h0020);

    // R8 interrupt status
    @(negedge clk); irq_evt = 8'h0F;
    @(negedge clk); irq_evt = 8'h00;
    bus_wr(1'b0, 16'h00F6);
    rd_chk("R8 events latched", 16'h000F);
    bus_wr(1'b0, 16'h00F6);
    bus_wr(1'b1, 16'h0005);
    bus_wr(1'b0, 16'h00F6);
    rd_chk("R8 write-zero clears", 16'h0005);

    // R4 dropped accesses
    bus_wr(1'b0, 16'h001C);
    load_skip(4'd2);
    bus_wr(1'b1, 16'h0000);
    check("R4 dropped write no flag", {15'b0, bad_idx}, 16'h0000);
    bus_rd(1'b1, d, v, b);
    check("R4 dropped read data", d, 16'h0000);
    check("R4 dropped read valid", {15'b0, v}, 16'h0001);
    rd_chk("R4 register and index untouched", 16'h007F);
    load_skip(4'd1);
    bus_wr(1'b0, 16'h0000);
    bus_rd(1'b1, d, v, b);
    check("R4 dropped index load", d, 16'h0000);
    check("R12 read of 0x1D flagged", {15'b0, b}, 16'h0001);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule